// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Controller

This controller sits between a single CPU request port and DRAM that is split into two banks: one bank holds the even word addresses and the other holds the odd ones. Each bank has its own RAS/CAS sequencer and its own busy/precharge timer, and the two run on their own. While one bank is precharging after an access, the other bank can take the next request. A program that steps through consecutive words therefore sees an access-time cost per word and not a full cycle-time cost.

The CPU raises `reqValid` with the address, direction and write data. It holds them until it sees `ack` for one clock, and only one request may be open at a time. Read data is valid on `rdData` in the acknowledge cycle. If a request targets a bank that is still precharging, the controller leaves it waiting with `ack` low until that bank's timer runs out. The address bit that picks the bank is dropped, and the remaining bits are split into a row half and a column half. These halves are driven one after the other on the selected bank's multiplexed address pins.

Top module: `dual_bank_dram_ctrl`

## Requirements
- R1: Bit 0 of `reqAddr` selects the bank. 0 selects bank 0 (index 0 of every per-bank pin vector) and 1 selects bank 1. Only the selected bank's RAS falls for a request.
- R2: In the first cycle of an access, the selected bank's address pins carry the row `reqAddr[ROW_W+COL_W:COL_W+1]` with RAS low and CAS high. When CAS falls, the pins carry the column `reqAddr[COL_W:1]`. Both fields are zero-extended to the pin width, and the bank bit is in neither.
- R3: A request is accepted at a rising clock edge A when `reqValid` is high, no access is in progress, and the target bank is ready. `ack` is then high during the cycle that follows edge A+ACC_CLK-1, so it comes ACC_CLK clocks after acceptance.
- R4: After accepting at edge A, a bank cannot accept again before edge A+ACC_CLK+PRE_CLK. Its RAS stays high for at least PRE_CLK cycles between two accesses. A request to a bank that is not ready waits with `ack` low.
- R5: `ack` is high for exactly one clock per accepted request and never rises without an open request.
- R6: During a read's `ack` cycle, `rdData` equals the word most recently written to that address (zero if the address was never written).
- R7: During a write, the bank's WE pin is low while its CAS is low, and its write-data pins carry the request's data. During a read, WE stays high.
- R8: While `rstN` is low, every RAS, CAS and WE pin is high and `ack` is low.
- R9: CAS of a bank is low only while RAS of that bank is also low.
- R10: The `ack` cycle accepts no request. If a request to the other bank is presented immediately after `ack`, it is accepted at the next edge, one clock after the `ack` cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | CPU request strobe, held until `ack` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W+1 | Word address; bit 0 selects the bank |
| reqWdata | input | DATA_W | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Read data, valid with `ack` |
| memAddr | output | 2 x max(ROW_W,COL_W) | Per-bank multiplexed row/column address |
| memRasN | output | 2 | Per-bank row strobe, active low |
| memCasN | output | 2 | Per-bank column strobe, active low |
| memWeN | output | 2 | Per-bank write enable, active low |
| memWdata | output | 2 x DATA_W | Per-bank write data |
| memRdata | input | 2 x DATA_W | Per-bank read data |

## Verification
A bank timer that is left in the wrong state shows at the ports at the very next request to that bank. `ack` arrives one or more clocks earlier or later than the bench's timing model predicts, or RAS falls before the bank has been precharged for PRE_CLK clocks. A wrong bank decode or a wrong address split shows within one or two clocks of acceptance, as a row or column on the pins that does not match the request. If the wrong bank is chosen, the data read back later does not match. A stuck or repeated acknowledge is caught in the cycle after it appears, because each `ack` has to match one queued request.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

  // Per-bank control strobes, active high, handed from control to datapath.
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
  } bankStb_t;

  typedef enum logic {
    CTL_IDLE,
    CTL_ACCESS
  } ctlState_t;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_ACT,
    BK_PRE
  } bankState_t;

endpackage

// File: rtl/dbk_bank_seq.sv
module dbk_bank_seq #(
  parameter int ACC_CLK = 2,
  parameter int PRE_CLK = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  output logic              ready,
  output logic              lastAcc,
  output dbk_pkg::bankStb_t stb
);
  import dbk_pkg::*;

  localparam int MAX_CLK = (ACC_CLK > PRE_CLK) ? ACC_CLK : PRE_CLK;
  localparam int CNT_W   = $clog2(MAX_CLK + 1);
  localparam int HI_W    = $clog2(PRE_CLK + 1);

  bankState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             wrLat;
  logic [HI_W-1:0]  hiCnt;

  // Ready when idle, or in the last precharge cycle (next edge may restart).
  assign ready   = (state == BK_IDLE) || (state == BK_PRE && cnt == '0);
  assign lastAcc = (state == BK_ACT) && (cnt == '0);

  assign stb.ras = (state == BK_ACT);
  assign stb.cas = (state == BK_ACT) && (cnt != CNT_W'(ACC_CLK - 1));
  assign stb.we  = stb.cas && wrLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= BK_IDLE;
      cnt   <= '0;
      wrLat <= 1'b0;
    end else if (start) begin
      state <= BK_ACT;
      cnt   <= CNT_W'(ACC_CLK - 1);
      wrLat <= isWrite;
    end else begin
      case (state)
        BK_ACT: begin
          if (cnt == '0) begin
            state <= BK_PRE;
            cnt   <= CNT_W'(PRE_CLK - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BK_PRE: begin
          if (cnt == '0) state <= BK_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= BK_IDLE;
      endcase
    end
  end

  // Count of consecutive RAS-high cycles, saturating, for the precharge check.
  always_ff @(posedge clk) begin
    if (!rstN)                       hiCnt <= HI_W'(PRE_CLK);
    else if (stb.ras)                hiCnt <= '0;
    else if (hiCnt != HI_W'(PRE_CLK)) hiCnt <= hiCnt + 1'b1;
  end

  // R4: row strobe only reasserts after a full precharge interval
  p_precharge_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.ras) |-> (int'($past(hiCnt)) >= PRE_CLK - 1));

  // R9: column strobe nested inside row strobe
  p_cas_in_ras_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.cas |-> stb.ras);

  // R7: write enable only alongside column strobe
  p_we_cas_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.we |-> stb.cas);

endmodule

// File: rtl/dbk_ctrl.sv
module dbk_ctrl #(
  parameter int ACC_CLK = 2,
  parameter int PRE_CLK = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic                    reqBank,
  output logic                    ack,
  output logic                    loadReq,
  output logic                    actBank,
  output dbk_pkg::bankStb_t [1:0] bankStb
);
  import dbk_pkg::*;

  localparam int NUM_BANKS = 2;
  localparam int WC_W      = $clog2(ACC_CLK + 1);

  ctlState_t             ctlState;
  logic [NUM_BANKS-1:0]  bankReady;
  logic [NUM_BANKS-1:0]  bankLast;
  logic [NUM_BANKS-1:0]  bankStart;
  logic                  accept;
  logic [WC_W-1:0]       waitCnt;

  assign accept  = (ctlState == CTL_IDLE) && reqValid && bankReady[reqBank];
  assign loadReq = accept;
  assign ack     = (ctlState == CTL_ACCESS) && bankLast[actBank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankStart[b] = accept && (reqBank == 1'(b));

    dbk_bank_seq #(
      .ACC_CLK (ACC_CLK),
      .PRE_CLK (PRE_CLK)
    ) seq_i (
      .clk     (clk),
      .rstN    (rstN),
      .start   (bankStart[b]),
      .isWrite (reqWrite),
      .ready   (bankReady[b]),
      .lastAcc (bankLast[b]),
      .stb     (bankStb[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlState <= CTL_IDLE;
      actBank  <= 1'b0;
    end else begin
      case (ctlState)
        CTL_IDLE: if (accept) begin
          ctlState <= CTL_ACCESS;
          actBank  <= reqBank;
        end
        CTL_ACCESS: if (ack) ctlState <= CTL_IDLE;
        default: ctlState <= CTL_IDLE;
      endcase
    end
  end

  // Cycles spent in the current access, used only by the latency check.
  always_ff @(posedge clk) begin
    if (!rstN)                                            waitCnt <= '0;
    else if (accept)                                      waitCnt <= '0;
    else if (ctlState == CTL_ACCESS && waitCnt != WC_W'(ACC_CLK)) waitCnt <= waitCnt + 1'b1;
  end

  // R3: acknowledge lands exactly ACC_CLK clocks after acceptance
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (int'(waitCnt) == ACC_CLK - 1));

  // R5: acknowledge is a single-clock pulse
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R1: the bank whose row strobe starts is the one the address bit picked
  p_bank_sel0_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bankStb[0].ras) |-> !$past(reqBank));
  p_bank_sel1_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bankStb[1].ras) |-> $past(reqBank));

  // R10: no new access starts in the acknowledge cycle
  p_no_accept_on_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !$rose(bankStb[0].ras) && !$rose(bankStb[1].ras));

endmodule

// File: rtl/dbk_datapath.sv
module dbk_datapath #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  logic                                           loadReq,
  input  logic [ROW_W+COL_W-1:0]                         reqRowCol,
  input  logic [DATA_W-1:0]                              reqWdata,
  input  logic                                           actBank,
  input  dbk_pkg::bankStb_t [1:0]                        bankStb,
  input  logic [1:0][DATA_W-1:0]                         memRdata,
  output logic [1:0][(ROW_W > COL_W ? ROW_W : COL_W)-1:0] memAddr,
  output logic [1:0]                                     memRasN,
  output logic [1:0]                                     memCasN,
  output logic [1:0]                                     memWeN,
  output logic [1:0][DATA_W-1:0]                         memWdata,
  output logic [DATA_W-1:0]                              rdData
);
  localparam int MUX_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NUM_BANKS = 2;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [DATA_W-1:0] wdReg;
  logic [MUX_W-1:0]  rowPad;
  logic [MUX_W-1:0]  colPad;

  // Bank bit is already stripped: column in the low half, row in the high half.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      wdReg  <= '0;
    end else if (loadReq) begin
      rowReg <= reqRowCol[ROW_W+COL_W-1:COL_W];
      colReg <= reqRowCol[COL_W-1:0];
      wdReg  <= reqWdata;
    end
  end

  assign rowPad = MUX_W'(rowReg);
  assign colPad = MUX_W'(colReg);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pins
    assign memAddr[b]  = bankStb[b].cas ? colPad : rowPad;
    assign memRasN[b]  = ~bankStb[b].ras;
    assign memCasN[b]  = ~bankStb[b].cas;
    assign memWeN[b]   = ~bankStb[b].we;
    assign memWdata[b] = wdReg;
  end

  assign rdData = memRdata[actBank];

endmodule

// File: rtl/dual_bank_dram_ctrl.sv
module dual_bank_dram_ctrl #(
  parameter int ROW_W   = 8,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int ACC_CLK = 2,
  parameter int PRE_CLK = 2
) (
  input  logic                                           clk,
  input  logic                                           rstN,
  input  logic                                           reqValid,
  input  logic                                           reqWrite,
  input  logic [ROW_W+COL_W:0]                           reqAddr,
  input  logic [DATA_W-1:0]                              reqWdata,
  output logic                                           ack,
  output logic [DATA_W-1:0]                              rdData,
  output logic [1:0][(ROW_W > COL_W ? ROW_W : COL_W)-1:0] memAddr,
  output logic [1:0]                                     memRasN,
  output logic [1:0]                                     memCasN,
  output logic [1:0]                                     memWeN,
  output logic [1:0][DATA_W-1:0]                         memWdata,
  input  logic [1:0][DATA_W-1:0]                         memRdata
);
  localparam int ADDR_W = ROW_W + COL_W + 1;

  dbk_pkg::bankStb_t [1:0] bankStb;
  logic                    loadReq;
  logic                    actBank;

  dbk_ctrl #(
    .ACC_CLK (ACC_CLK),
    .PRE_CLK (PRE_CLK)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqBank  (reqAddr[0]),
    .ack      (ack),
    .loadReq  (loadReq),
    .actBank  (actBank),
    .bankStb  (bankStb)
  );

  dbk_datapath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .loadReq   (loadReq),
    .reqRowCol (reqAddr[ADDR_W-1:1]),
    .reqWdata  (reqWdata),
    .actBank   (actBank),
    .bankStb   (bankStb),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memRasN   (memRasN),
    .memCasN   (memCasN),
    .memWeN    (memWeN),
    .memWdata  (memWdata),
    .rdData    (rdData)
  );

endmodule

// File: tb/dual_bank_dram_ctrl_tb_top.sv
module dual_bank_dram_ctrl_tb_top;
  localparam int ROW_W   = 8;
  localparam int COL_W   = 8;
  localparam int DATA_W  = 16;
  localparam int ACC_CLK = 2;
  localparam int PRE_CLK = 2;
  localparam int ADDR_W  = ROW_W + COL_W + 1;
  localparam int MUX_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic ack;
  logic [DATA_W-1:0] rdData;
  logic [1:0][MUX_W-1:0] memAddr;
  logic [1:0] memRasN, memCasN, memWeN;
  logic [1:0][DATA_W-1:0] memWdata;
  logic [1:0][DATA_W-1:0] memRdata = '0;

  dual_bank_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .ACC_CLK(ACC_CLK), .PRE_CLK(PRE_CLK)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ack(ack), .rdData(rdData),
    .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- DRAM bank models (environment) ----------------
  logic [DATA_W-1:0] cellMem0 [int];
  logic [DATA_W-1:0] cellMem1 [int];
  logic [MUX_W-1:0]  rowLat [2];
  logic [1:0]        rasSeen = 2'b11;

  always begin
    @(posedge clk);
    #1;
    for (int b = 0; b < 2; b++) begin
      int key;
      if (!memRasN[b] && rasSeen[b]) rowLat[b] = memAddr[b];
      rasSeen[b] = memRasN[b];
      key = int'(rowLat[b]) * (1 << MUX_W) + int'(memAddr[b]);
      if (!memCasN[b] && !memWeN[b]) begin
        if (b == 0) cellMem0[key] = memWdata[b];
        else        cellMem1[key] = memWdata[b];
      end
      memRdata[b] = '0;
      if (!memCasN[b]) begin
        if (b == 0 && cellMem0.exists(key)) memRdata[b] = cellMem0[key];
        if (b == 1 && cellMem1.exists(key)) memRdata[b] = cellMem1[key];
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit                isWr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    int                ackCyc;
    string             tag;
  } sbItem_t;

  sbItem_t sbq[$];
  logic [DATA_W-1:0] refMem [int];
  int readyAt [2] = '{0, 0};
  int freeAt = 0;

  task automatic doAccess(input bit isWr, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] data);
    sbItem_t it;
    int b = int'(addr[0]);
    int earliest;
    int accEdge;
    earliest = (cyc + 1 > freeAt) ? cyc + 1 : freeAt;
    accEdge  = (readyAt[b] > earliest) ? readyAt[b] : earliest;
    if (readyAt[b] > earliest)  it.tag = "R4";   // same bank still precharging
    else if (freeAt > cyc + 1)  it.tag = "R10";  // turnaround after previous ack
    else                        it.tag = "R3";   // fresh request, ready bank
    it.isWr   = isWr;
    it.addr   = addr;
    it.ackCyc = accEdge + ACC_CLK - 1;
    if (isWr) begin
      refMem[int'(addr)] = data;
      it.data = data;
    end else begin
      it.data = refMem.exists(int'(addr)) ? refMem[int'(addr)] : '0;
    end
    readyAt[b] = accEdge + ACC_CLK + PRE_CLK;
    freeAt     = accEdge + ACC_CLK + 1;
    sbq.push_back(it);
    reqValid = 1'b1;
    reqWrite = isWr;
    reqAddr  = addr;
    reqWdata = data;
    do @(negedge clk); while (!ack);
    reqValid = 1'b0;
    reqWrite = 1'b0;
  endtask

  // ---------------- monitor ----------------
  logic       prevAck = 1'b0;
  logic [1:0] prevRas = 2'b11;
  logic [1:0] prevCas = 2'b11;

  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int b = 0; b < 2; b++) begin
        if (!memCasN[b]) chk(!memRasN[b], "R9", "CAS without RAS", memRasN[b], 0);
        if (!memRasN[b] && prevRas[b]) begin
          if (sbq.size() == 0) chk(1'b0, "R1", "RAS fell with no request", b, 0);
          else begin
            chk(sbq[0].addr[0] == 1'(b), "R1", "bank chosen", b, sbq[0].addr[0]);
            chk(memAddr[b] == MUX_W'(sbq[0].addr[ADDR_W-1:COL_W+1]), "R2", "row on pins",
                memAddr[b], sbq[0].addr[ADDR_W-1:COL_W+1]);
            chk(memCasN[b] == 1'b1, "R2", "RAS-only first cycle", memCasN[b], 1);
          end
        end
        if (!memCasN[b] && prevCas[b] && sbq.size() > 0) begin
          chk(memAddr[b] == MUX_W'(sbq[0].addr[COL_W:1]), "R2", "column on pins",
              memAddr[b], sbq[0].addr[COL_W:1]);
          chk(memWeN[b] == !sbq[0].isWr, "R7", "WE level", memWeN[b], !sbq[0].isWr);
          if (sbq[0].isWr)
            chk(memWdata[b] == sbq[0].data, "R7", "write data", memWdata[b], sbq[0].data);
        end
      end
      if (ack) begin
        chk(!prevAck, "R5", "ack longer than one clock", 1, 0);
        if (sbq.size() == 0) chk(1'b0, "R5", "ack with no request", 1, 0);
        else begin
          sbItem_t it;
          it = sbq.pop_front();
          chk(cyc == it.ackCyc, it.tag, "ack cycle", cyc, it.ackCyc);
          if (!it.isWr) chk(rdData == it.data, "R6", "read data", rdData, it.data);
        end
      end
    end
    prevAck = ack;
    prevRas = memRasN;
    prevCas = memCasN;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R8: reset state of every pin and ack
    chk(memRasN == 2'b11, "R8", "RAS in reset", memRasN, 3);
    chk(memCasN == 2'b11, "R8", "CAS in reset", memCasN, 3);
    chk(memWeN == 2'b11, "R8", "WE in reset", memWeN, 3);
    chk(ack == 1'b0, "R8", "ack in reset", ack, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: isolated access
    doAccess(1'b1, 17'h00010, 16'hA5A5);
    repeat (3) @(negedge clk);

    // R3/R10: alternating even/odd writes then reads, back to back
    for (int i = 0; i < 8; i++) doAccess(1'b1, ADDR_W'(32'h100 + i), DATA_W'(32'h1000 + i * 32'h111));
    for (int i = 0; i < 8; i++) doAccess(1'b0, ADDR_W'(32'h100 + i), '0);

    // R4: same bank back to back stalls for precharge
    for (int i = 0; i < 4; i++) doAccess(1'b1, ADDR_W'(32'h200 + 2 * i), DATA_W'(32'h2200 + i));
    for (int i = 0; i < 4; i++) doAccess(1'b0, ADDR_W'(32'h200 + 2 * i), '0);
    for (int i = 0; i < 3; i++) doAccess(1'b0, ADDR_W'(32'h201 + 2 * i), '0);

    // R3: same bank after an idle gap needs no wait
    repeat (6) @(negedge clk);
    doAccess(1'b0, 17'h00204, '0);
    repeat (2) @(negedge clk);

    // R2: extreme row/column fields
    doAccess(1'b1, 17'h1FFFF, 16'hBEEF);
    doAccess(1'b1, 17'h1FFFE, 16'hCAFE);
    doAccess(1'b1, 17'h00001, 16'h0F0F);
    doAccess(1'b1, 17'h1FE00, 16'h1234);
    doAccess(1'b0, 17'h1FFFF, '0);
    doAccess(1'b0, 17'h1FFFE, '0);
    doAccess(1'b0, 17'h00001, '0);
    doAccess(1'b0, 17'h1FE00, '0);
    doAccess(1'b0, 17'h00010, '0);

    // Mixed traffic over a small pool of addresses
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[6]) repeat (int'(lfsr[5:4])) @(negedge clk);
      doAccess(lfsr[3], ADDR_W'(32'h300 + lfsr[2:0]), lfsr ^ 16'h5A00);
    end

    repeat (6) @(negedge clk);
    chk(sbq.size() == 0, "R5", "requests left without ack", sbq.size(), 0);
    chk(ack == 1'b0, "R5", "ack idle after traffic", ack, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule